// File: doc/BRIEF.md
# I2C Target Interface Engine

This block answers on an I2C bus as a target with a 7-bit address. Software sets the own address and the enable through a small register file. The engine then watches the bus for START, address, direction, data bytes and STOP. It acknowledges matching addresses, stores received bytes, and sends bytes that software places in a single shared data register. Each bus event sets a sticky status flag. Software clears a flag by writing 0 to it. A per-bit enable mask turns the flags into one interrupt line.

The bus inputs arrive already synchronized and deglitched. Both outputs are pull-low enables for open-drain pads. On a read transfer the engine holds SCL low while it has no byte to send. Software can refuse a received byte by setting a forced-NACK control bit before that byte is acknowledged. Software can also enable a response to the general-call address.

Top module: `i2c_target_engine`

## Requirements
- R1: After reset, every register reads 0, both pull-low outputs are 0 and `irq` is 0.
- R2: The register offsets are: 0 control, 1 status, 2 interrupt enable, 3 own address, 4 data. The control register holds four bits: bit0 forced NACK, bit1 general-call enable, bit2 target enable, bit3 buffer-mode select. The own address register keeps the low 7 bits of a write. Every register reads back what was written.
- R3: The status bits are: bit0 address matched, bit1 byte received, bit2 byte transmitted, bit3 transmit data empty, bit4 STOP seen, bit5 transmit (read) mode, bit6 general call. Writing the status register clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a bit.
- R4: `irq` is 1 exactly when some status bit and the interrupt-enable bit at the same position are both 1.
- R5: An address byte whose upper 7 bits equal a nonzero own address is acknowledged on the 9th clock and sets bit0. With R/W=0, bit5 stays 0. An address that does not match gets no acknowledge and sets no address flag.
- R6: When general-call enable is set, address byte 0x00 is acknowledged and sets bit0 and bit6. When general-call enable is clear, the same byte is not acknowledged.
- R7: In a write transfer, each received byte (MSB first) is loaded into the data register, sets bit1, and is acknowledged.
- R8: If the forced-NACK bit is 1 when a received data byte is acknowledged, the engine leaves SDA released (NACK) for that byte. The byte is still stored and still sets bit1.
- R9: A matching address with R/W=1 sets bits 0, 3 and 5. After the acknowledge, SCL is held low until software writes the data register. That byte is then sent MSB first.
- R10: After each sent byte, bit2 is set. If the master acknowledges, bit3 is set and SCL is held again. If the master does not acknowledge, SDA and SCL are both released and the engine waits for STOP or START.
- R11: While enabled, a STOP sets bit4 even when the transfer was addressed to another target, and releases both lines.
- R12: With the target enable at 0, the engine does not acknowledge any address, does not pull either line, and sets no flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write value |
| regRdData | output | 8 | Register read value (combinational) |
| sclIn | input | 1 | Filtered SCL level |
| sdaIn | input | 1 | Filtered SDA level |
| sclPullLow | output | 1 | Drive SCL low when 1 |
| sdaPullLow | output | 1 | Drive SDA low when 1 |
| irq | output | 1 | Masked status interrupt |

## Verification
The hardest situation to reach from the ports is the read path. In it, the engine stretches SCL, a byte written late is shifted out, and the master then ends the transfer with a NACK. The bench builds a wired-AND bus from the master model and the engine's pull-low outputs. Its master waits for SCL to actually rise before counting a clock. This lets it sit in the stretched state, check the hold, and then release it with a data write. A second read byte is then answered with NACK, and the bench confirms that both lines are let go before STOP.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int DW     = 8;
  localparam int AW     = 7;
  localparam int REG_AW = 3;
  localparam int CTRL_W = 4;
  localparam int STAT_W = 7;
  localparam int CNT_W  = $clog2(DW + 1);

  localparam int CT_NACK = 0;
  localparam int CT_GCEN = 1;
  localparam int CT_EN   = 2;
  localparam int CT_BUF  = 3;

  localparam int ST_ADDR   = 0;
  localparam int ST_RXD    = 1;
  localparam int ST_TXD    = 2;
  localparam int ST_TXE    = 3;
  localparam int ST_STOP   = 4;
  localparam int ST_TXMODE = 5;
  localparam int ST_GCALL  = 6;

  localparam logic [REG_AW-1:0] RA_CTRL = REG_AW'(0);
  localparam logic [REG_AW-1:0] RA_STAT = REG_AW'(1);
  localparam logic [REG_AW-1:0] RA_IEN  = REG_AW'(2);
  localparam logic [REG_AW-1:0] RA_OWN  = REG_AW'(3);
  localparam logic [REG_AW-1:0] RA_DATA = REG_AW'(4);

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_ACK_SETUP, PH_ACK_DRIVE, PH_RX,
    PH_TX_WAIT, PH_TX, PH_TX_ACK, PH_WAIT_STOP
  } phase_t;

  typedef struct packed {
    logic              shiftIn;
    logic              loadRx;
    logic              loadTx;
    logic              shiftOut;
    logic              dropTx;
    logic [STAT_W-1:0] setFlags;
  } ctlStrb_t;

  typedef struct packed {
    logic enable;
    logic forceNack;
    logic addrHit;
    logic gcHit;
    logic rwBit;
    logic txFull;
    logic txFirstBit;
    logic txNextBit;
  } dpView_t;
endpackage

// File: rtl/i2ct_dp.sv
module i2ct_dp
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  input  logic              sdaBit,
  input  ctlStrb_t          strb,
  output dpView_t           view,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [STAT_W-1:0] statReg;
  logic [STAT_W-1:0] ienReg;
  logic [AW-1:0]     ownAddr;
  logic [DW-1:0]     dataReg;
  logic [DW-1:0]     shiftReg;
  logic              txFull;
  logic [DW-1:0]     rxByte;
  logic [STAT_W-1:0] statKeep;
  logic              dataWr;

  assign rxByte   = {shiftReg[DW-2:0], sdaBit};
  assign dataWr   = regWrEn && (regAddr == RA_DATA);
  assign statKeep = (regWrEn && regAddr == RA_STAT) ? regWrData[STAT_W-1:0] : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      statReg  <= '0;
      ienReg   <= '0;
      ownAddr  <= '0;
      dataReg  <= '0;
      shiftReg <= '0;
      txFull   <= 1'b0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          RA_CTRL: ctrlReg <= regWrData[CTRL_W-1:0];
          RA_IEN:  ienReg  <= regWrData[STAT_W-1:0];
          RA_OWN:  ownAddr <= regWrData[AW-1:0];
          default: ;
        endcase
      end
      statReg <= (statReg & statKeep) | strb.setFlags;
      if (strb.loadRx)   dataReg <= rxByte;
      else if (dataWr)   dataReg <= regWrData;
      if (dataWr)                          txFull <= 1'b1;
      else if (strb.loadTx || strb.dropTx) txFull <= 1'b0;
      if (strb.shiftIn)       shiftReg <= rxByte;
      else if (strb.loadTx)   shiftReg <= dataReg;
      else if (strb.shiftOut) shiftReg <= {shiftReg[DW-2:0], shiftReg[DW-1]};
    end
  end

  always_comb begin
    case (regAddr)
      RA_CTRL: regRdData = {{(DW-CTRL_W){1'b0}}, ctrlReg};
      RA_STAT: regRdData = {{(DW-STAT_W){1'b0}}, statReg};
      RA_IEN:  regRdData = {{(DW-STAT_W){1'b0}}, ienReg};
      RA_OWN:  regRdData = {{(DW-AW){1'b0}}, ownAddr};
      RA_DATA: regRdData = dataReg;
      default: regRdData = '0;
    endcase
  end

  assign view.enable     = ctrlReg[CT_EN];
  assign view.forceNack  = ctrlReg[CT_NACK];
  assign view.addrHit    = (ownAddr != '0) && (rxByte[DW-1:1] == ownAddr);
  assign view.gcHit      = ctrlReg[CT_GCEN] && (rxByte[DW-1:1] == '0) && !rxByte[0];
  assign view.rwBit      = rxByte[0];
  assign view.txFull     = txFull;
  assign view.txFirstBit = dataReg[DW-1];
  assign view.txNextBit  = shiftReg[DW-2];

  assign irq = |(statReg & ienReg);

  AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRx |=> statReg[ST_RXD]);  // R7
  AST_STAT_WRITE_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == RA_STAT && strb.setFlags == '0)
      |=> ((statReg & ~$past(statReg)) == '0));  // R3
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  dpView_t  view,
  output ctlStrb_t strb,
  output logic     sclPullLow,
  output logic     sdaPullLow
);
  phase_t           phase, phaseN;
  logic [CNT_W-1:0] bitCnt, bitCntN;
  logic             sclPrev, sdaPrev;
  logic             sdaDrive, sdaDriveN;
  logic             isRead, isReadN;
  logic             ackIsData, ackIsDataN;
  logic             ackOk, ackOkN;
  logic             sclRise, sclFall, startDet, stopDet;

  assign sclRise  = sclIn && !sclPrev;
  assign sclFall  = !sclIn && sclPrev;
  assign startDet = sclIn && sclPrev && sdaPrev && !sdaIn;
  assign stopDet  = sclIn && sclPrev && !sdaPrev && sdaIn;

  always_comb begin
    phaseN     = phase;
    bitCntN    = bitCnt;
    sdaDriveN  = sdaDrive;
    isReadN    = isRead;
    ackIsDataN = ackIsData;
    ackOkN     = ackOk;
    strb       = '0;
    if (!view.enable) begin
      phaseN    = PH_IDLE;
      bitCntN   = '0;
      sdaDriveN = 1'b0;
      isReadN   = 1'b0;
    end else if (startDet) begin
      phaseN      = PH_ADDR;
      bitCntN     = '0;
      sdaDriveN   = 1'b0;
      isReadN     = 1'b0;
      strb.dropTx = 1'b1;
    end else if (stopDet) begin
      phaseN                 = PH_IDLE;
      sdaDriveN              = 1'b0;
      isReadN                = 1'b0;
      strb.dropTx            = 1'b1;
      strb.setFlags[ST_STOP] = 1'b1;
    end else begin
      case (phase)
        PH_ADDR: if (sclRise) begin
          strb.shiftIn = 1'b1;
          bitCntN      = bitCnt + 1'b1;
          if (bitCnt == CNT_W'(DW-1)) begin
            if (view.addrHit || view.gcHit) begin
              strb.setFlags[ST_ADDR]   = 1'b1;
              strb.setFlags[ST_TXMODE] = view.rwBit && view.addrHit;
              strb.setFlags[ST_TXE]    = view.rwBit && view.addrHit && !view.txFull;
              strb.setFlags[ST_GCALL]  = view.gcHit;
              isReadN    = view.rwBit && view.addrHit;
              ackIsDataN = 1'b0;
              phaseN     = PH_ACK_SETUP;
            end else begin
              phaseN = PH_WAIT_STOP;
            end
          end
        end
        PH_RX: if (sclRise) begin
          strb.shiftIn = 1'b1;
          bitCntN      = bitCnt + 1'b1;
          if (bitCnt == CNT_W'(DW-1)) begin
            strb.loadRx           = 1'b1;
            strb.setFlags[ST_RXD] = 1'b1;
            ackIsDataN            = 1'b1;
            phaseN                = PH_ACK_SETUP;
          end
        end
        PH_ACK_SETUP: if (sclFall) begin
          sdaDriveN = !(ackIsData && view.forceNack);
          phaseN    = PH_ACK_DRIVE;
        end
        PH_ACK_DRIVE: if (sclFall) begin
          sdaDriveN = 1'b0;
          bitCntN   = '0;
          phaseN    = isRead ? PH_TX_WAIT : PH_RX;
        end
        PH_TX_WAIT: if (view.txFull) begin
          strb.loadTx = 1'b1;
          sdaDriveN   = !view.txFirstBit;
          bitCntN     = '0;
          phaseN      = PH_TX;
        end
        PH_TX: begin
          if (sclRise) begin
            bitCntN = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == CNT_W'(DW)) begin
              sdaDriveN             = 1'b0;
              strb.setFlags[ST_TXD] = 1'b1;
              phaseN                = PH_TX_ACK;
            end else begin
              strb.shiftOut = 1'b1;
              sdaDriveN     = !view.txNextBit;
            end
          end
        end
        PH_TX_ACK: begin
          if (sclRise) begin
            ackOkN = !sdaIn;
          end else if (sclFall) begin
            if (ackOk) begin
              phaseN                = PH_TX_WAIT;
              strb.setFlags[ST_TXE] = !view.txFull;
            end else begin
              phaseN = PH_WAIT_STOP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      bitCnt    <= '0;
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      sdaDrive  <= 1'b0;
      isRead    <= 1'b0;
      ackIsData <= 1'b0;
      ackOk     <= 1'b0;
    end else begin
      phase     <= phaseN;
      bitCnt    <= bitCntN;
      sclPrev   <= sclIn;
      sdaPrev   <= sdaIn;
      sdaDrive  <= sdaDriveN;
      isRead    <= isReadN;
      ackIsData <= ackIsDataN;
      ackOk     <= ackOkN;
    end
  end

  assign sdaPullLow = sdaDrive;
  assign sclPullLow = (phase == PH_TX_WAIT);

  AST_HOLD_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    sclPullLow |-> isRead);  // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !view.enable |=> (!sdaPullLow && !sclPullLow));  // R12
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && view.enable) |=> (!sdaPullLow && !sclPullLow));  // R11
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow,
  output logic              irq
);
  ctlStrb_t strb;
  dpView_t  view;

  i2ct_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .view       (view),
    .strb       (strb),
    .sclPullLow (sclPullLow),
    .sdaPullLow (sdaPullLow)
  );

  i2ct_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .sdaBit    (sdaIn),
    .strb      (strb),
    .view      (view),
    .irq       (irq)
  );
endmodule

// File: tb/test_i2c_target_engine.sv
module test_i2c_target_engine;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       sclPullLow, sdaPullLow, irq;
  logic       mSclLow = 1'b0, mSdaLow = 1'b0;
  logic       sclBus, sdaBus;
  int         nChecks = 0, nFails = 0;
  bit         finished = 1'b0;

  assign sclBus = !(mSclLow || sclPullLow);
  assign sdaBus = !(mSdaLow || sdaPullLow);

  always #10 clk = ~clk;

  i2c_target_engine i_i2c_target_engine (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sclIn(sclBus),
    .sdaIn(sdaBus), .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow), .irq(irq));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic sclUp();
    mSclLow = 1'b0;
    while (!sclBus) @(negedge clk);
  endtask

  task automatic mStart();
    mSdaLow = 1'b0; sclUp(); idle(4);
    mSdaLow = 1'b1; idle(4);
    mSclLow = 1'b1; idle(3);
  endtask

  task automatic mStop();
    mSdaLow = 1'b1; idle(3);
    sclUp(); idle(4);
    mSdaLow = 1'b0; idle(6);
  endtask

  task automatic mWriteByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      mSdaLow = !b[i]; idle(3);
      sclUp(); idle(4);
      mSclLow = 1'b1; idle(3);
    end
    mSdaLow = 1'b0; idle(3);
    sclUp(); idle(2);
    acked = !sdaBus; idle(2);
    mSclLow = 1'b1; idle(3);
  endtask

  task automatic mReadByte(input logic giveAck, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      mSdaLow = 1'b0; idle(3);
      sclUp(); idle(2);
      b = {b[6:0], sdaBus}; idle(2);
      mSclLow = 1'b1; idle(3);
    end
    mSdaLow = giveAck; idle(3);
    sclUp(); idle(4);
    mSclLow = 1'b1; idle(3);
    mSdaLow = 1'b0; idle(2);
  endtask

  task automatic tReset();
    logic [7:0] v;
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), v);
      check("R1", $sformatf("reg %0d after reset", a), v, 8'h00);
    end
    check("R1", "sclPullLow after reset", sclPullLow, 1'b0);
    check("R1", "sdaPullLow after reset", sdaPullLow, 1'b0);
    check("R1", "irq after reset", irq, 1'b0);
  endtask

  task automatic tRegs();
    logic [7:0] v;
    regWrite(3'd0, 8'h0C); regRead(3'd0, v); check("R2", "control readback", v, 8'h0C);
    regWrite(3'd3, 8'hAC); regRead(3'd3, v); check("R2", "own address 7 bits", v, 8'h2C);
    regWrite(3'd2, 8'h10); regRead(3'd2, v); check("R2", "irq enable readback", v, 8'h10);
    regWrite(3'd4, 8'h5A); regRead(3'd4, v); check("R2", "data readback", v, 8'h5A);
    regWrite(3'd0, 8'h04);
  endtask

  task automatic tWriteXfer();
    logic ack; logic [7:0] v;
    mStart();
    mWriteByte(8'h58, ack); check("R5", "address ack", ack, 1'b1);
    regRead(3'd1, v); check("R5", "status after write address", v, 8'h01);
    mWriteByte(8'h9E, ack); check("R7", "data ack", ack, 1'b1);
    regRead(3'd4, v); check("R7", "first byte stored", v, 8'h9E);
    mWriteByte(8'h41, ack); check("R7", "second data ack", ack, 1'b1);
    regRead(3'd4, v); check("R7", "second byte stored", v, 8'h41);
    mStop();
    regRead(3'd1, v); check("R11", "status after stop", v, 8'h13);
  endtask

  task automatic tStatusClear();
    logic [7:0] v;
    regWrite(3'd1, 8'hEF); regRead(3'd1, v); check("R3", "clear stop bit only", v, 8'h03);
    regWrite(3'd1, 8'hFE); regRead(3'd1, v); check("R3", "clear address bit only", v, 8'h02);
    regWrite(3'd1, 8'hFF); regRead(3'd1, v); check("R3", "write ones keeps", v, 8'h02);
    regWrite(3'd1, 8'h00); regRead(3'd1, v); check("R3", "clear all", v, 8'h00);
  endtask

  task automatic tMismatchIrq();
    logic ack; logic [7:0] v;
    check("R4", "irq idle", irq, 1'b0);
    mStart();
    mWriteByte(8'hA0, ack); check("R5", "other address not acked", ack, 1'b0);
    regRead(3'd1, v); check("R5", "no address flag", v, 8'h00);
    mStop();
    regRead(3'd1, v); check("R11", "stop for other target", v, 8'h10);
    check("R4", "irq with enabled flag", irq, 1'b1);
    regWrite(3'd2, 8'h01); idle(1); check("R4", "irq masked", irq, 1'b0);
    regWrite(3'd2, 8'h10); idle(1); check("R4", "irq unmasked", irq, 1'b1);
    regWrite(3'd1, 8'hEF); idle(1); check("R4", "irq after clear", irq, 1'b0);
  endtask

  task automatic tForceNack();
    logic ack; logic [7:0] v;
    regWrite(3'd0, 8'h05);
    mStart();
    mWriteByte(8'h58, ack); check("R8", "address still acked", ack, 1'b1);
    mWriteByte(8'h77, ack); check("R8", "data nacked", ack, 1'b0);
    regRead(3'd4, v); check("R8", "nacked byte stored", v, 8'h77);
    regRead(3'd1, v); check("R8", "received flag set", v, 8'h03);
    mStop();
    regWrite(3'd0, 8'h04); regWrite(3'd1, 8'h00);
  endtask

  task automatic tGeneralCall();
    logic ack; logic [7:0] v;
    regWrite(3'd0, 8'h06);
    mStart();
    mWriteByte(8'h00, ack); check("R6", "general call acked", ack, 1'b1);
    regRead(3'd1, v); check("R6", "general call flags", v, 8'h41);
    mStop(); regWrite(3'd1, 8'h00);
    regWrite(3'd0, 8'h04);
    mStart();
    mWriteByte(8'h00, ack); check("R6", "general call off not acked", ack, 1'b0);
    mStop();
    regRead(3'd1, v); check("R6", "only stop flag", v, 8'h10);
    regWrite(3'd1, 8'h00);
  endtask

  task automatic tRead();
    logic ack; logic [7:0] v, b;
    mStart();
    mWriteByte(8'h59, ack); check("R9", "read address acked", ack, 1'b1);
    idle(5);
    check("R9", "scl held while empty", sclPullLow, 1'b1);
    regRead(3'd1, v); check("R9", "read match flags", v, 8'h29);
    regWrite(3'd1, 8'h00);
    regWrite(3'd4, 8'hC6);
    mReadByte(1'b1, b); check("R9", "first byte MSB first", b, 8'hC6);
    regRead(3'd1, v); check("R10", "sent and empty flags", v, 8'h0C);
    check("R10", "scl held after master ack", sclPullLow, 1'b1);
    regWrite(3'd1, 8'h00);
    regWrite(3'd4, 8'h1D);
    mReadByte(1'b0, b); check("R10", "second byte", b, 8'h1D);
    idle(4);
    check("R10", "sda released after nack", sdaPullLow, 1'b0);
    check("R10", "scl released after nack", sclPullLow, 1'b0);
    regRead(3'd1, v); check("R10", "sent flag without empty", v, 8'h04);
    mStop();
    regRead(3'd1, v); check("R11", "stop after read", v, 8'h14);
    regWrite(3'd1, 8'h00);
  endtask

  task automatic tDisabled();
    logic ack; logic [7:0] v;
    regWrite(3'd0, 8'h00);
    mStart();
    mWriteByte(8'h58, ack); check("R12", "disabled no ack", ack, 1'b0);
    mStop();
    regRead(3'd1, v); check("R12", "disabled no flags", v, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    endRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    tReset();
    tRegs();
    tWriteXfer();
    tStatusClear();
    tMismatchIrq();
    tForceNack();
    tGeneralCall();
    tRead();
    tDisabled();
    endRun();
  end
endmodule